// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block computes the quotient or the remainder of two integers for a processor execution pipeline. One restoring shift-and-subtract engine serves four operations: signed and unsigned, each giving the quotient or the remainder. The dividend always comes from a register operand. The divisor comes either from a second register operand or from a short immediate field. A signed operation sign-extends the immediate, and an unsigned operation zero-extends it.

A request is accepted with a one-cycle `start` pulse while the unit is idle. The unit raises `busy` and spends one setup cycle and then `WIDTH` iteration cycles. It then pulses `done` for one cycle. The result, the destination register index and a valid strobe are presented with that pulse. When the divisor is zero, the unit signals a divide exception with `done` and writes no result. A destination index of zero also suppresses the valid strobe, because register zero is never written.

Top module: `int_divider`

## Requirements
- R1: After reset, `busy`, `done`, `res_valid` and `div_zero_exc` are all low.
- R2: With `op` = 00 the result is the unsigned quotient `a / b`, and with `op` = 01 it is the unsigned remainder `a % b`. `op[1]` selects signed and `op[0]` selects remainder.
- R3: With `op` = 10 the signed quotient is truncated toward zero. With `op` = 11 the signed remainder has the sign of the dividend, so that quotient times divisor plus remainder equals the dividend.
- R4: A signed division of the most negative value by -1 returns the most negative value as the quotient and 0 as the remainder, and raises no exception.
- R5: If the divisor is zero, `done` pulses together with `div_zero_exc`, and `res_valid` stays low.
- R6: When `use_imm` is 1, the divisor is the `IMM_W`-bit `imm`. It is sign-extended for signed operations and zero-extended for unsigned ones. The zero test is always made on the sign-extended immediate.
- R7: A request with `dest` = 0 still pulses `done`, but `res_valid` stays low. In any other case, `res_dest` equals the requested `dest`.
- R8: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`. `done` is high for exactly one cycle. For a nonzero divisor, `done` appears `WIDTH`+2 edges after the accepting edge. For a zero divisor it appears 1 edge after it.
- R9: A `start` pulse while `busy` is high is ignored, and the running operation completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| op | input | 2 | Bit 1 = signed, bit 0 = remainder |
| use_imm | input | 1 | Take the divisor from `imm` instead of `opnd_b` |
| imm | input | IMM_W | Immediate divisor field |
| opnd_a | input | WIDTH | Dividend |
| opnd_b | input | WIDTH | Register divisor |
| dest | input | REG_AW | Destination register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Result is to be written |
| result | output | WIDTH | Quotient or remainder |
| res_dest | output | REG_AW | Destination index of the result |
| div_zero_exc | output | 1 | Divide-by-zero exception, pulsed with `done` |

## Verification
The bench builds the unit with `WIDTH` = 5 and `IMM_W` = 3. At that size every dividend/divisor pair for all four operations in register form can be swept, and so can every dividend against every immediate. This covers the zero divisor, the most-negative-by-minus-one case and every sign combination, including the immediates whose extension differs between signed and unsigned. The destination index is varied with the operands, so register zero occurs throughout the sweep. The latency and the handshake are measured on every request. A separate case fires `start` during an operation.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIN   = 2'd3
  } div_state_t;

  localparam int OP_REM_BIT = 0;
  localparam int OP_SGN_BIT = 1;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             sgn,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_b,
  output logic             neg_a,
  output logic             neg_b,
  output logic             zero_div
);
  localparam int PAD = WIDTH - IMM_W;

  logic [WIDTH-1:0] imm_sx, imm_zx, dvs;

  always_comb begin
    imm_sx = {{PAD{imm[IMM_W-1]}}, imm};
    imm_zx = {{PAD{1'b0}}, imm};
    if (use_imm) dvs = sgn ? imm_sx : imm_zx;
    else         dvs = b;
    // the zero test on an immediate is made on its sign-extended value
    zero_div = use_imm ? (imm_sx == '0) : (b == '0);
    neg_a = sgn & a[WIDTH-1];
    neg_b = sgn & dvs[WIDTH-1];
    mag_a = neg_a ? (~a + 1'b1) : a;
    mag_b = neg_b ? (~dvs + 1'b1) : dvs;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  logic [WIDTH:0]   part_q;
  logic [WIDTH-1:0] quo_q, dvs_q;
  logic [WIDTH:0]   shifted, diff;

  always_comb begin
    shifted = {part_q[WIDTH-1:0], quo_q[WIDTH-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      part_q <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
    end else if (step) begin
      if (diff[WIDTH]) begin
        part_q <= shifted;
        quo_q  <= {quo_q[WIDTH-2:0], 1'b0};
      end else begin
        part_q <= diff;
        quo_q  <= {quo_q[WIDTH-2:0], 1'b1};
      end
    end
  end

  assign quo = quo_q;
  assign rem = part_q[WIDTH-1:0];
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic             neg_a,
  input  logic             neg_b,
  input  logic             want_rem,
  output logic [WIDTH-1:0] value
);
  logic             flip;
  logic [WIDTH-1:0] pick;

  always_comb begin
    pick  = want_rem ? rem_mag : quo_mag;
    flip  = want_rem ? neg_a : (neg_a ^ neg_b);
    value = flip ? (~pick + 1'b1) : pick;
  end
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int WIDTH  = 32,
  parameter int IMM_W  = 16,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic [REG_AW-1:0] dest,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic [WIDTH-1:0]  result,
  output logic [REG_AW-1:0] res_dest,
  output logic              div_zero_exc
);
  import div_pkg::*;

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  div_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op_q;
  logic              imm_sel_q;
  logic [IMM_W-1:0]  imm_q;
  logic [WIDTH-1:0]  a_q, b_q;
  logic [REG_AW-1:0] dest_q;
  logic              neg_a_q, neg_b_q;

  logic [WIDTH-1:0]  mag_a, mag_b, quo_mag, rem_mag, fixed;
  logic              neg_a, neg_b, zero_div;
  logic              core_load, core_step;

  div_operand_prep #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_prep (
    .sgn      (op_q[OP_SGN_BIT]),
    .use_imm  (imm_sel_q),
    .imm      (imm_q),
    .a        (a_q),
    .b        (b_q),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .neg_a    (neg_a),
    .neg_b    (neg_b),
    .zero_div (zero_div)
  );

  assign core_load = (state == ST_SETUP) && !zero_div;
  assign core_step = (state == ST_ITER);

  div_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (core_load),
    .step     (core_step),
    .dividend (mag_a),
    .divisor  (mag_b),
    .quo      (quo_mag),
    .rem      (rem_mag)
  );

  div_result_fix #(.WIDTH(WIDTH)) u_fix (
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .neg_a    (neg_a_q),
    .neg_b    (neg_b_q),
    .want_rem (op_q[OP_REM_BIT]),
    .value    (fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      op_q         <= '0;
      imm_sel_q    <= 1'b0;
      imm_q        <= '0;
      a_q          <= '0;
      b_q          <= '0;
      dest_q       <= '0;
      neg_a_q      <= 1'b0;
      neg_b_q      <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      res_valid    <= 1'b0;
      result       <= '0;
      res_dest     <= '0;
      div_zero_exc <= 1'b0;
    end else begin
      done         <= 1'b0;
      res_valid    <= 1'b0;
      div_zero_exc <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q      <= op;
            imm_sel_q <= use_imm;
            imm_q     <= imm;
            a_q       <= opnd_a;
            b_q       <= opnd_b;
            dest_q    <= dest;
            busy      <= 1'b1;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (zero_div) begin
            done         <= 1'b1;
            div_zero_exc <= 1'b1;
            res_dest     <= dest_q;
            busy         <= 1'b0;
            state        <= ST_IDLE;
          end else begin
            neg_a_q <= neg_a;
            neg_b_q <= neg_b;
            cnt     <= '0;
            state   <= ST_ITER;
          end
        end
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          done      <= 1'b1;
          res_valid <= (dest_q != '0);
          result    <= fixed;
          res_dest  <= dest_q;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_divider_checker.sv
module int_divider_checker #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              res_valid,
  input logic [REG_AW-1:0] res_dest,
  input logic              div_zero_exc
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_falls_on_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_start_raises_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done) |=> busy);

  p_exc_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    div_zero_exc |-> (done && !res_valid));

  p_no_write_reg0_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_dest != '0) && done);

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));
endmodule

bind int_divider int_divider_checker #(.REG_AW(REG_AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .res_valid    (res_valid),
  .res_dest     (res_dest),
  .div_zero_exc (div_zero_exc)
);

// File: tb/tb_int_divider.sv
module tb_int_divider;
  localparam int W = 5;
  localparam int IW = 3;
  localparam int RA = 5;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = '0;
  logic          use_imm = 1'b0;
  logic [IW-1:0] imm = '0;
  logic [W-1:0]  opnd_a = '0, opnd_b = '0;
  logic [RA-1:0] dest = '0;
  logic          busy, done, res_valid, div_zero_exc;
  logic [W-1:0]  result;
  logic [RA-1:0] res_dest;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_divider #(.WIDTH(W), .IMM_W(IW), .REG_AW(RA)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .use_imm(use_imm),
    .imm(imm), .opnd_a(opnd_a), .opnd_b(opnd_b), .dest(dest),
    .busy(busy), .done(done), .res_valid(res_valid), .result(result),
    .res_dest(res_dest), .div_zero_exc(div_zero_exc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= (1 << (W-1))) ? v - (1 << W) : v;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // Runs one request. The divisor value used is dv; zero test uses zt.
  // interfere: pulse start with other operands while busy (R9).
  task automatic run_op(input int o, input int a, input int dv, input bit zt,
                        input bit im, input int iv, input int b,
                        input int d, input bit interfere, input string req);
    int n;
    int exp_val;
    int sa, sd, m;
    m = (1 << W) - 1;
    @(negedge clk);
    op = o[1:0]; use_imm = im; imm = iv[IW-1:0];
    opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; dest = d[RA-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R8 busy after start", busy, 1);
    if (interfere) begin
      op = ~op; opnd_a = ~opnd_a; opnd_b = 1; use_imm = 0; dest = ~dest; start = 1'b1;
    end
    n = 0;
    while (done !== 1'b1 && n < 3*W) begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    if (zt) begin
      check(n == 1, "R8 zero latency", n, 1);
      check(div_zero_exc === 1'b1 && res_valid === 1'b0, "R5 exception", div_zero_exc, 1);
    end else begin
      check(n == W + 2, "R8 latency", n, W + 2);
      check(div_zero_exc === 1'b0, "R5 no exception", div_zero_exc, 0);
      check(res_valid === (d != 0), "R7 valid vs dest", res_valid, d != 0);
      check(res_dest == d[RA-1:0], "R7 dest", res_dest, d);
      if (o[1]) begin
        sa = to_signed(a); sd = to_signed(dv);
        exp_val = (o[0] ? (sa % sd) : (sa / sd)) & m;
      end else begin
        exp_val = (o[0] ? (a % dv) : (a / dv)) & m;
      end
      check(result == exp_val[W-1:0], req, result, exp_val);
    end
    check(busy === 1'b0, "R8 busy low at done", busy, 0);
    @(negedge clk);
    check(done === 1'b0, "R8 done single", done, 0);
  endtask

  initial begin
    int ext;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 0 && done === 0 && res_valid === 0 && div_zero_exc === 0,
          "R1 reset state", {busy, done, res_valid, div_zero_exc}, 0);

    // R4 most negative by -1, signed quotient and remainder
    run_op(2, 1 << (W-1), (1 << W) - 1, 0, 0, 0, (1 << W) - 1, 3, 0, "R4 min/-1 quotient");
    run_op(3, 1 << (W-1), (1 << W) - 1, 0, 0, 0, (1 << W) - 1, 3, 0, "R4 min/-1 remainder");

    // R9 start during busy is ignored
    run_op(3, 27, 5, 0, 0, 0, 5, 9, 1, "R9 ignored restart");

    // register forms: R2 unsigned, R3 signed, R5 zero, R7 dest 0 when (a+b)%32==0
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_op(o, a, b, b == 0, 0, 0, b, (a + b) % (1 << RA), 0,
                 o[1] ? "R3 signed reg" : "R2 unsigned reg");

    // immediate forms: R6
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < (1 << W); a++)
        for (int iv = 0; iv < (1 << IW); iv++) begin
          if (o[1] && iv >= (1 << (IW-1))) ext = (iv - (1 << IW)) & ((1 << W) - 1);
          else ext = iv;
          run_op(o, a, ext, iv == 0, 1, iv, 7, (a + iv + 1) % (1 << RA), 0,
                 "R6 immediate form");
        end

    finish_run();
  end
endmodule